// File: doc/BRIEF.md
# I2C Bus Master with Control Register

This block is a single-master I2C controller driven by a small word-addressed register file. Software starts a bus transaction by setting a master bit in the control register, which produces a START condition. It then writes the data register once per byte. In transmit mode that write sends the byte and captures the acknowledge returned by the target. In receive mode the write clocks in a byte and answers with an acknowledge level chosen by software. Clearing the master bit ends the transaction with a STOP condition. A repeated-start bit restarts the bus without releasing it.

SCL and SDA are open-drain. The block only ever pulls a line low through an output-enable, and it reads SDA back. This readback detects loss of arbitration: the block released SDA high, but the bus shows it low. On that event the block drops off the bus without a STOP and clears its mode bits. An interrupt flag marks either a completed byte or an arbitration loss. The interrupt pin is that flag gated by an interrupt-enable bit. A module-enable bit works as a soft reset of the bus engine while the registers stay writable. The SCL rate comes from a divider register.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the control and status words read 0, the irq output is 0 and both SCL and SDA are released.
- R2: Control word (word 0) layout: bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit (1) / receive (0), bit 3 acknowledge level sent when receiving, bit 2 repeated start. Bits 31..8 of every word read 0 and writes to them are ignored.
- R3: While the enable bit is 0, both lines are released, no bus condition is produced and no other control bit acts. The control word, the status word (word 1) and the divider word (word 3) stay writable and read back what was written. The data word (word 2) reads 0 and ignores writes. Clearing enable during a transfer releases both lines.
- R4: With enable set, a 0-to-1 change of the master bit makes SDA fall while SCL is high (START), after which SCL is held low. A 1-to-0 change makes SDA rise while SCL is high (STOP) and releases the bus. Status bit 5 reads 1 while the block owns the bus.
- R5: In transmit mode, a data-word write sends bits 7..0 MSB first on eight SCL pulses. SDA is released on the ninth pulse, and its sampled level is stored in status bit 0 (0 means acknowledged).
- R6: In receive mode, a data-word write (value ignored) clocks in eight bits MSB first, which the data word then returns. On the ninth pulse SDA is pulled low when control bit 3 is 0 and released when it is 1.
- R7: Status bit 1 is set when a byte completes. irq is 1 only when status bit 1 and control bit 6 are both 1. Clearing bit 6 does not clear status bit 1. Writing the status word sets bits 1 and 4 to the written values.
- R8: If SDA reads low at an SCL high sample point of a transmitted data bit while the block is releasing it, the block releases both lines with no STOP. It clears control bits 5 and 4 and sets status bits 4 and 1.
- R9: Writing 1 to control bit 2 while the master bit is already 1 produces a repeated START without a STOP, and the bit then reads 0. When the master bit was 0 beforehand, the write leaves the bit at 0.
- R10: Each SCL period inside a byte lasts 4*(D+1) clock cycles, where D is the value of the divider word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for bus_addr, one cycle later |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |
| irq | output | 1 | Interrupt request |

## Verification
The bench models a target that can acknowledge, return a byte, or pull SDA low on a chosen bit to take arbitration. A monitor decodes START, STOP and every bit from the two lines. The first corner case is arbitration loss mid-byte: a design that emitted a STOP, or kept its mode bits set, would show up as an extra STOP count or a nonzero mode field. Next, a repeated start must add one START and no STOP and then clear its own bit; a design that ignored the master precondition would accept the bit while idle. Finally, clearing interrupt enable must not clear the pending flag, and a disabled module must ignore data writes and keep the bus quiet. A wrong design would lose the flag or drive the lines.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_START,
    ENG_HOLD,
    ENG_XFER,
    ENG_STOP,
    ENG_RSTRT
  } eng_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_DIV  = 2'd3;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int NB = BYTE_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          want,
  input  logic          rstart_req,
  input  logic          xfer_req,
  input  logic          tx_mode,
  input  logic          ack_bit,
  input  logic [NB-1:0] tx_byte,
  input  logic          sda_in,
  output logic          scl_lo,
  output logic          sda_lo,
  output logic [NB-1:0] rx_byte,
  output logic          rx_ack,
  output logic          done,
  output logic          arb_lost,
  output logic          rstart_take,
  output logic          xfer_take,
  output logic          in_xfer,
  output logic          busy
);
  localparam int BCW = $clog2(NB + 1);
  localparam logic [BCW-1:0] ACK_IDX = BCW'(NB);

  eng_state_t     state;
  logic [1:0]     qc;
  logic [BCW-1:0] bc;
  logic [NB-1:0]  shift;

  assign in_xfer = (state == ENG_XFER);
  assign busy    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    done        <= 1'b0;
    arb_lost    <= 1'b0;
    rstart_take <= 1'b0;
    xfer_take   <= 1'b0;
    if (rst) begin
      state   <= ENG_IDLE;
      qc      <= '0;
      bc      <= '0;
      scl_lo  <= 1'b0;
      sda_lo  <= 1'b0;
      shift   <= '0;
      rx_byte <= '0;
      rx_ack  <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ENG_IDLE: begin
          scl_lo <= 1'b0;
          sda_lo <= 1'b0;
          qc     <= '0;
          if (want) state <= ENG_START;
        end
        ENG_START: begin
          qc <= qc + 1'b1;
          if (qc == 2'd0) begin
            sda_lo <= 1'b1;
          end else begin
            scl_lo <= 1'b1;
            qc     <= '0;
            state  <= ENG_HOLD;
          end
        end
        ENG_HOLD: begin
          qc <= '0;
          if (!want) begin
            state <= ENG_STOP;
          end else if (rstart_req) begin
            state       <= ENG_RSTRT;
            rstart_take <= 1'b1;
          end else if (xfer_req) begin
            state     <= ENG_XFER;
            xfer_take <= 1'b1;
            shift     <= tx_byte;
            bc        <= '0;
          end
        end
        ENG_XFER: begin
          qc <= qc + 1'b1;
          unique case (qc)
            2'd0: begin
              if (bc == ACK_IDX) sda_lo <= !tx_mode && !ack_bit;
              else               sda_lo <= tx_mode && !shift[NB-1];
            end
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              if (bc != ACK_IDX) begin
                shift <= {shift[NB-2:0], sda_in};
                if (tx_mode && !sda_lo && !sda_in) begin
                  state    <= ENG_IDLE;
                  scl_lo   <= 1'b0;
                  sda_lo   <= 1'b0;
                  arb_lost <= 1'b1;
                end
              end else if (tx_mode) begin
                rx_ack <= sda_in;
              end
            end
            default: begin
              scl_lo <= 1'b1;
              if (bc == ACK_IDX) begin
                state   <= ENG_HOLD;
                done    <= 1'b1;
                rx_byte <= shift;
              end else begin
                bc <= bc + 1'b1;
              end
            end
          endcase
        end
        ENG_STOP: begin
          qc <= qc + 1'b1;
          unique case (qc)
            2'd0: sda_lo <= 1'b1;
            2'd1: scl_lo <= 1'b0;
            default: begin
              sda_lo <= 1'b0;
              state  <= ENG_IDLE;
            end
          endcase
        end
        default: begin
          qc <= qc + 1'b1;
          unique case (qc)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin
              scl_lo <= 1'b1;
              qc     <= '0;
              state  <= ENG_HOLD;
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int          DIV_W    = 8,
  parameter logic [7:0]  DIV_INIT = 8'd49
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        irq
);
  localparam int NB = BYTE_BITS;

  logic men, mien, msta, mtx, txak, rsta;
  logic if_flag, al_flag, pend;
  logic [NB-1:0]    tx_q;
  logic [DIV_W-1:0] div_q;
  logic tick, done, arb_lost, rstart_take, xfer_take, in_xfer, busy, rx_ack;
  logic [NB-1:0] rx_byte;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[31:8];

  wire wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  wire wr_stat = bus_wr && (bus_addr == REG_STAT);
  wire wr_data = bus_wr && (bus_addr == REG_DATA);
  wire wr_div  = bus_wr && (bus_addr == REG_DIV);
  wire eng_rst = rst || !men;

  always_ff @(posedge clk) begin
    if (rst) begin
      men <= 1'b0; mien <= 1'b0; msta <= 1'b0;
      mtx <= 1'b0; txak <= 1'b0; rsta <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        men  <= bus_wdata[7];
        mien <= bus_wdata[6];
        msta <= bus_wdata[5];
        mtx  <= bus_wdata[4];
        txak <= bus_wdata[3];
        rsta <= bus_wdata[2] && bus_wdata[5] && bus_wdata[7] && msta && men;
      end
      if (rstart_take) rsta <= 1'b0;
      if (arb_lost) begin
        msta <= 1'b0;
        mtx  <= 1'b0;
        rsta <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_flag <= 1'b0;
      al_flag <= 1'b0;
    end else begin
      if (wr_stat) begin
        if_flag <= bus_wdata[1];
        al_flag <= bus_wdata[4];
      end
      if (done || arb_lost) if_flag <= 1'b1;
      if (arb_lost)         al_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      pend  <= 1'b0;
      div_q <= DIV_INIT[DIV_W-1:0];
    end else begin
      if (xfer_take || !men || !msta) pend <= 1'b0;
      if (wr_data && men) begin
        tx_q <= bus_wdata[NB-1:0];
        pend <= msta;
      end
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= mien && if_flag;
      unique case (bus_addr)
        REG_CTRL: bus_rdata <= {24'd0, men, mien, msta, mtx, txak, rsta, 2'b00};
        REG_STAT: bus_rdata <= {26'd0, busy, al_flag, 2'b00, if_flag, rx_ack};
        REG_DATA: bus_rdata <= men ? {{(32-NB){1'b0}}, rx_byte} : '0;
        default:  bus_rdata <= {{(32-DIV_W){1'b0}}, div_q};
      endcase
    end
  end

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (eng_rst),
    .div  (div_q),
    .tick (tick)
  );

  i2cm_engine #(.NB(NB)) u_eng (
    .clk         (clk),
    .rst         (eng_rst),
    .tick        (tick),
    .want        (msta),
    .rstart_req  (rsta),
    .xfer_req    (pend),
    .tx_mode     (mtx),
    .ack_bit     (txak),
    .tx_byte     (tx_q),
    .sda_in      (sda_in),
    .scl_lo      (scl_oe),
    .sda_lo      (sda_oe),
    .rx_byte     (rx_byte),
    .rx_ack      (rx_ack),
    .done        (done),
    .arb_lost    (arb_lost),
    .rstart_take (rstart_take),
    .xfer_take   (xfer_take),
    .in_xfer     (in_xfer),
    .busy        (busy)
  );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic men,
  input logic mien,
  input logic msta,
  input logic mtx,
  input logic rsta,
  input logic if_flag,
  input logic al_flag,
  input logic irq,
  input logic scl_oe,
  input logic sda_oe,
  input logic arb_lost,
  input logic rstart_take,
  input logic in_xfer
);
  AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !men |=> (!scl_oe && !sda_oe)); // R3

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !mien |=> !irq); // R7

  AST_ARB_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> (!msta && !mtx && al_flag && if_flag)); // R8

  AST_ARB_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> (!scl_oe && !sda_oe)); // R8

  AST_RSTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rstart_take |=> !rsta); // R9

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (in_xfer && $past(in_xfer) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe)); // R5
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .men         (men),
  .mien        (mien),
  .msta        (msta),
  .mtx         (mtx),
  .rsta        (rsta),
  .if_flag     (if_flag),
  .al_flag     (al_flag),
  .irq         (irq),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .arb_lost    (arb_lost),
  .rstart_take (rstart_take),
  .in_xfer     (in_xfer)
);

// File: tb/i2cm_ctrl_tb.sv
`timescale 1ns/1ps
module i2cm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_oe, sda_oe, irq;
  logic        slv_drv = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_cnt = 0, stop_cnt = 0, ridx = 0, last_rise = 0, mon_per = 0;
  logic [7:0] mon_sh = '0, mon_byte = '0;
  logic       mon_ack = 1'b0;
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  int         slv_mode = 0;
  logic       ack_low = 1'b0;
  logic [7:0] sbyte = '0;
  int         arb_bit = 0;
  int         cur_div = 49;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_drv);

  always #2.5 clk = ~clk;

  i2cm_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq)
  );

  function automatic logic drv_fn(int b);
    if (slv_mode == 1) return (b == 8) && ack_low;
    if (slv_mode == 2) return (b < 8) && !sbyte[7-b];
    if (slv_mode == 3) return (b == arb_bit);
    return 1'b0;
  endfunction

  // bus monitor and target model
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    prev_scl <= scl_line;
    prev_sda <= sda_line;
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      start_cnt <= start_cnt + 1;
      ridx      <= 0;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      stop_cnt <= stop_cnt + 1;
    end
    if (scl_line && !prev_scl) begin
      if ((ridx % 9) < 8) mon_sh <= {mon_sh[6:0], sda_line};
      if ((ridx % 9) == 7) mon_byte <= {mon_sh[6:0], sda_line};
      if ((ridx % 9) == 8) mon_ack <= sda_line;
      if ((ridx % 9) != 0) mon_per <= cyc - last_rise;
      last_rise <= cyc;
      ridx      <= ridx + 1;
    end
    if (slv_mode == 0)  slv_drv <= 1'b0;
    else if (!scl_line) slv_drv <= drv_fn(ridx % 9);
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_flag(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd1, st);
      if (st[1]) break;
    end
  endtask

  task automatic settle();
    repeat (12 * (cur_div + 1) + 10) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    cur_div = d;
    bus_write(2'd3, d);
  endtask

  initial begin
    logic [31:0] rd, st;
    int sc, pc;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); chk("R1 ctrl reset", rd, 0);
    bus_read(2'd1, rd); chk("R1 status reset", rd, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 lines released", {scl_line, sda_line}, 2'b11);

    // R2/R3/R9 disabled writes
    bus_write(2'd0, 32'hFFFF_FF7C);
    bus_read(2'd0, rd); chk("R2 R9 ctrl reserved+rsta", rd, 32'h78);
    repeat (40) @(negedge clk);
    chk("R3 no start while disabled", start_cnt, 0);
    chk("R3 lines idle while disabled", {scl_line, sda_line}, 2'b11);
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h5A);
    bus_read(2'd2, rd); chk("R3 data blocked", rd, 0);
    bus_write(2'd1, 32'h12);
    bus_read(2'd1, rd); chk("R3 status writable", rd, 32'h12);
    bus_write(2'd1, 32'h0);
    set_div(3);
    bus_read(2'd3, rd); chk("R3 R10 divider readback", rd, 3);

    // R4 start
    bus_write(2'd0, 32'hC0);
    bus_write(2'd0, 32'hF0);
    settle();
    chk("R4 start seen", start_cnt, 1);
    chk("R4 scl held low", scl_line, 0);
    bus_read(2'd1, rd); chk("R4 busy", rd[5], 1);

    // R5 R7 R10 transmit
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      logic a;
      d = 8'($urandom);
      a = 1'($urandom);
      if (k == 0) d = 8'h80;
      if (k == 1) d = 8'h01;
      set_div(1 + int'($urandom % 5));
      ack_low = a; slv_mode = 1;
      bus_write(2'd2, {24'd0, d});
      wait_flag(st);
      chk("R5 tx byte on bus", mon_byte, d);
      chk("R5 rx ack status", st[0], a ? 1'b0 : 1'b1);
      chk("R7 irq on done", irq, 1);
      chk("R10 scl period", mon_per, 4 * (cur_div + 1));
      bus_write(2'd1, 32'h0);
      slv_mode = 0;
    end

    // R6 receive
    for (int k = 0; k < 6; k++) begin
      logic t;
      t = 1'($urandom);
      sbyte = (k == 0) ? 8'h00 : 8'($urandom);
      bus_write(2'd0, 32'hE0 | (32'(t) << 3));
      slv_mode = 2;
      bus_write(2'd2, 32'hFF);
      wait_flag(st);
      slv_mode = 0;
      bus_read(2'd2, rd); chk("R6 rx data", rd, {24'd0, sbyte});
      chk("R6 ack level sent", mon_ack, t);
      if (k < 5) bus_write(2'd1, 32'h0);
    end

    // R7 gating keeps pending flag
    bus_write(2'd0, 32'hA0);
    repeat (3) @(negedge clk);
    chk("R7 irq gated", irq, 0);
    bus_read(2'd1, rd); chk("R7 flag kept", rd[1], 1);
    bus_write(2'd1, 32'h0);
    bus_read(2'd1, rd); chk("R7 flag cleared by write", rd[1], 0);

    // R9 repeated start
    sc = start_cnt; pc = stop_cnt;
    bus_write(2'd0, 32'hF4);
    settle();
    chk("R9 repeated start", start_cnt, sc + 1);
    chk("R9 no stop", stop_cnt, pc);
    bus_read(2'd0, rd); chk("R9 rsta self clear", rd, 32'hF0);
    ack_low = 1; slv_mode = 1;
    bus_write(2'd2, 32'hC3);
    wait_flag(st);
    slv_mode = 0;
    chk("R5 tx after restart", mon_byte, 8'hC3);
    bus_write(2'd1, 32'h0);

    // R4 stop
    bus_write(2'd0, 32'hD0);
    settle();
    chk("R4 stop seen", stop_cnt, pc + 1);
    bus_read(2'd1, rd); chk("R4 not busy", rd[5], 0);
    chk("R4 lines released", {scl_line, sda_line}, 2'b11);

    // R8 arbitration loss
    bus_write(2'd0, 32'hF0);
    settle();
    pc = stop_cnt;
    arb_bit = 2; slv_mode = 3;
    bus_write(2'd2, 32'hFF);
    wait_flag(st);
    chk("R8 al and if", {st[4], st[1]}, 2'b11);
    bus_read(2'd0, rd); chk("R8 mode bits cleared", rd, 32'hC0);
    chk("R8 no stop", stop_cnt, pc);
    chk("R8 scl released", scl_line, 1);
    slv_mode = 0;
    bus_write(2'd1, 32'h0);
    settle();

    // R3 disable mid transfer
    bus_write(2'd0, 32'hF0);
    settle();
    set_div(7);
    ack_low = 1; slv_mode = 1;
    bus_write(2'd2, 32'h00);
    repeat (40) @(negedge clk);
    bus_write(2'd0, 32'h70);
    slv_mode = 0;
    repeat (4) @(negedge clk);
    chk("R3 disable releases lines", {scl_line, sda_line}, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule